// File: doc/BRIEF.md
# Reset-Strapped Address and Status LED Pin Controller

This block controls a pair of shared pads that do two jobs. While the chip is held in reset, by either the power-on reset or the hardware reset, the pads are inputs. The block reads their levels and keeps them as two bits of the device's management address. When reset ends, the block turns the pads around and uses them as status lamp outputs. One lamp shows collisions. Each collision is stretched into a pulse long enough to see. The other lamp follows the link-valid level.

The collision strobe and the link level come from other clock domains. Each one passes through a synchronizer before it is used. The length of the collision pulse is given in clock cycles by a parameter, for example 70 ms multiplied by the clock frequency. A further parameter sets whether a lit lamp drives the pad low or high. The captured address bits are output continuously to the management logic. That logic is not part of this block, and neither are the pad cells or the pull resistors.

Top module: `strap_led_pin_ctrl`

## Requirements
- R1: Reset is active while `por_n` is low or `hw_rst_n` is low. During reset, `pad_oe` is 2'b00 and both `pad_out` bits sit at the unlit level. The unlit level is 0 when `LED_ACTIVE_LOW` is 0.
- R2: On every clock edge at which reset is active, `addr_strap[k]` loads `pad_in[k]`. A low pad gives 0 and a high pad gives 1. Bit 0 is the collision pad and bit 1 is the link pad. The value loaded at the last edge with reset active is the one kept.
- R3: After reset ends, `addr_strap` stays constant whatever `pad_in` does, until the next reset.
- R4: At the first clock edge after reset ends, `pad_oe` is still 2'b00. It becomes 2'b11 at that edge and stays 2'b11 while reset is inactive.
- R5: Once the pads are enabled, `pad_out[1]` is lit while `link_ok` is high and unlit while it is low. It follows `link_ok` two clock edges late.
- R6: A strobe on `coll_evt` that is high at one clock edge lights `pad_out[0]` from the third edge after that one. It keeps the lamp lit for exactly `STRETCH_CYCLES` cycles.
- R7: A new strobe that arrives while the collision lamp is lit restarts the full `STRETCH_CYCLES` count from that strobe.
- R8: A reset clears any stretch that is in progress. After reset ends, the collision lamp is unlit until a new strobe arrives.
- R9: Either reset input on its own, with the other one high, causes a fresh address capture and the pad turnaround.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low |
| hw_rst_n | input | 1 | Hardware reset, active low |
| pad_in | input | 2 | Pad input levels; bit 0 is the collision pad, bit 1 is the link pad |
| pad_out | output | 2 | Pad output levels (lamp drive) |
| pad_oe | output | 2 | Pad output enables, 1 means drive |
| coll_evt | input | 1 | Collision strobe, asynchronous |
| link_ok | input | 1 | Link-valid level, asynchronous |
| addr_strap | output | 2 | Captured address bits |

## Verification
The checker watches four things on every cycle. The enables must be off during reset. The captured address must be frozen outside reset. The enables must stay off for one cycle after release and then turn on. The link lamp must follow the link level two cycles late. It also checks that every rise of the collision lamp was caused by a strobe three cycles earlier. Some behaviour can only be shown by the bench's scenarios: the exact length of the stretched pulse, its restart when a second strobe arrives, the clearing of a stretch by reset, and the address bits captured under each reset source.

// File: rtl/strap_led_pkg.sv
package strap_led_pkg;
   localparam int PIN_COLL = 0;
   localparam int PIN_LINK = 1;
   localparam int NUM_PINS = 2;
   typedef logic [NUM_PINS-1:0] pin_vec_t;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic clr,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("strap_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (clr) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst_act,
   input  logic [WIDTH-1:0] pad_in,
   output logic [WIDTH-1:0] addr,
   output logic             run
);
   if (WIDTH < 1) begin : g_bad_width
      $error("strap_capture: WIDTH must be positive");
   end

   always_ff @(posedge clk) begin
      if (rst_act) begin
         addr <= pad_in;
         run  <= 1'b0;
      end else begin
         run  <= 1'b1;
      end
   end
endmodule

// File: rtl/coll_stretch.sv
module coll_stretch #(
   parameter int CYCLES = 8
) (
   input  logic clk,
   input  logic clr,
   input  logic evt,
   output logic lit
);
   if (CYCLES < 1) begin : g_bad_cycles
      $error("coll_stretch: CYCLES must be at least 1");
   end

   localparam int CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(CYCLES);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (clr)             cnt <= '0;
      else if (evt)        cnt <= LOAD;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign lit = (cnt != '0);
endmodule

// File: rtl/strap_led_pin_ctrl.sv
module strap_led_pin_ctrl
   import strap_led_pkg::*;
#(
   parameter int STRETCH_CYCLES = 8750000,
   parameter int SYNC_STAGES    = 2,
   parameter bit LED_ACTIVE_LOW = 1'b0
) (
   input  logic           clk,
   input  logic           por_n,
   input  logic           hw_rst_n,
   input  logic [1:0]     pad_in,
   output logic [1:0]     pad_out,
   output logic [1:0]     pad_oe,
   input  logic           coll_evt,
   input  logic           link_ok,
   output logic [1:0]     addr_strap
);
   logic     rst_act;
   logic     run;
   logic     coll_s;
   logic     link_s;
   logic     coll_lit;
   pin_vec_t lamp;

   assign rst_act = ~por_n | ~hw_rst_n;

   strap_capture #(.WIDTH(NUM_PINS)) cap_i (
      .clk     (clk),
      .rst_act (rst_act),
      .pad_in  (pad_in),
      .addr    (addr_strap),
      .run     (run)
   );

   strap_sync #(.STAGES(SYNC_STAGES)) sync_coll_i (
      .clk (clk), .clr (rst_act), .d (coll_evt), .q (coll_s)
   );

   strap_sync #(.STAGES(SYNC_STAGES)) sync_link_i (
      .clk (clk), .clr (rst_act), .d (link_ok), .q (link_s)
   );

   coll_stretch #(.CYCLES(STRETCH_CYCLES)) stretch_i (
      .clk (clk), .clr (rst_act), .evt (coll_s), .lit (coll_lit)
   );

   always_comb begin
      lamp           = '0;
      lamp[PIN_COLL] = coll_lit;
      lamp[PIN_LINK] = link_s;
      if (rst_act || !run) lamp = '0;
   end

   assign pad_oe = {NUM_PINS{run & ~rst_act}};

   if (LED_ACTIVE_LOW) begin : g_drive_low
      assign pad_out = ~lamp;
   end else begin : g_drive_high
      assign pad_out = lamp;
   end
endmodule

// File: rtl/strap_led_pin_ctrl_chk.sv
module strap_led_pin_ctrl_chk #(
   parameter bit LED_ACTIVE_LOW = 1'b0
) (
   input logic       clk,
   input logic       por_n,
   input logic       hw_rst_n,
   input logic [1:0] pad_out,
   input logic [1:0] pad_oe,
   input logic       coll_evt,
   input logic       link_ok,
   input logic [1:0] addr_strap
);
   logic       rst_act;
   logic [1:0] lamp;
   logic       prev_rst  = 1'b1;
   logic [1:0] prev_addr = 2'b00;
   logic [2:0] since     = 3'd0;

   assign rst_act = ~por_n | ~hw_rst_n;
   assign lamp    = pad_out ^ {2{LED_ACTIVE_LOW}};

   always_ff @(posedge clk) begin
      prev_rst  <= rst_act;
      prev_addr <= addr_strap;
      if (rst_act)          since <= 3'd0;
      else if (since != 3'd7) since <= since + 3'd1;
   end

   // R1
   oe_off_in_reset_chk: assert property (@(posedge clk)
      rst_act |-> (pad_oe == 2'b00));

   // R3
   addr_hold_chk: assert property (@(posedge clk) disable iff (rst_act)
      !prev_rst |-> (addr_strap == prev_addr));

   // R4
   oe_turnaround_chk: assert property (@(posedge clk) disable iff (rst_act)
      prev_rst |-> (pad_oe == 2'b00));

   // R4
   oe_on_chk: assert property (@(posedge clk) disable iff (rst_act)
      (since >= 3'd2) |-> (pad_oe == 2'b11));

   // R5
   link_follow_chk: assert property (@(posedge clk) disable iff (rst_act)
      (since >= 3'd3) |-> (lamp[1] == $past(link_ok, 2)));

   // R6
   coll_origin_chk: assert property (@(posedge clk) disable iff (rst_act)
      ((since >= 3'd4) && $rose(lamp[0])) |-> $past(coll_evt, 3));
endmodule

bind strap_led_pin_ctrl strap_led_pin_ctrl_chk #(.LED_ACTIVE_LOW(LED_ACTIVE_LOW)) chk_i (
   .clk        (clk),
   .por_n      (por_n),
   .hw_rst_n   (hw_rst_n),
   .pad_out    (pad_out),
   .pad_oe     (pad_oe),
   .coll_evt   (coll_evt),
   .link_ok    (link_ok),
   .addr_strap (addr_strap)
);

// File: tb/strap_led_pin_ctrl_tb_top.sv
module strap_led_pin_ctrl_tb_top;
   localparam int N = 20;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       hw_rst_n = 1'b0;
   logic [1:0] pad_in = 2'b00;
   logic [1:0] pad_out;
   logic [1:0] pad_oe;
   logic       coll_evt = 1'b0;
   logic       link_ok = 1'b0;
   logic [1:0] addr_strap;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   strap_led_pin_ctrl #(.STRETCH_CYCLES(N), .SYNC_STAGES(2), .LED_ACTIVE_LOW(1'b0)) dut_i (
      .clk (clk), .por_n (por_n), .hw_rst_n (hw_rst_n), .pad_in (pad_in),
      .pad_out (pad_out), .pad_oe (pad_oe), .coll_evt (coll_evt),
      .link_ok (link_ok), .addr_strap (addr_strap)
   );

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic do_release(input logic [1:0] strap, input bit use_por);
      pad_in = strap;
      if (use_por) por_n = 1'b0; else hw_rst_n = 1'b0;
      wait_cyc(3);
      check("R1 oe off in reset", pad_oe, 2'b00);
      check("R1 pads unlit in reset", pad_out, 2'b00);
      por_n = 1'b1; hw_rst_n = 1'b1;
      check("R4 oe off at release", pad_oe, 2'b00);
      check("R2 strap captured", addr_strap, strap);
      wait_cyc(1);
      check("R4 oe on after turnaround", pad_oe, 2'b11);
   endtask

   task automatic t_reset_and_strap();
      wait_cyc(2);
      check("R1 oe off at start", pad_oe, 2'b00);
      do_release(2'b10, 1'b1);
      check("R9 por strap value", addr_strap, 2'b10);
   endtask

   task automatic t_addr_hold();
      pad_in = 2'b01;
      wait_cyc(3);
      check("R3 addr held", addr_strap, 2'b10);
      pad_in = 2'b11;
      wait_cyc(2);
      check("R3 addr held again", addr_strap, 2'b10);
   endtask

   task automatic t_link();
      link_ok = 1'b1;
      wait_cyc(1);
      check("R5 link latency", {1'b0, pad_out[1]}, 2'b00);
      wait_cyc(1);
      check("R5 link lit", {1'b0, pad_out[1]}, 2'b01);
      link_ok = 1'b0;
      wait_cyc(2);
      check("R5 link unlit", {1'b0, pad_out[1]}, 2'b00);
   endtask

   task automatic strobe();
      coll_evt = 1'b1;
      wait_cyc(1);
      coll_evt = 1'b0;
   endtask

   task automatic t_coll_single();
      strobe();
      wait_cyc(1);
      check("R6 coll not yet lit", {1'b0, pad_out[0]}, 2'b00);
      wait_cyc(1);
      check("R6 coll lit", {1'b0, pad_out[0]}, 2'b01);
      wait_cyc(N - 1);
      check("R6 coll lit at end", {1'b0, pad_out[0]}, 2'b01);
      wait_cyc(1);
      check("R6 coll off after stretch", {1'b0, pad_out[0]}, 2'b00);
   endtask

   task automatic t_coll_retrigger();
      strobe();
      wait_cyc(2);
      check("R7 first lit", {1'b0, pad_out[0]}, 2'b01);
      wait_cyc(5);
      strobe();
      wait_cyc(2 + N - 1);
      check("R7 extended", {1'b0, pad_out[0]}, 2'b01);
      wait_cyc(1);
      check("R7 off after restart", {1'b0, pad_out[0]}, 2'b00);
   endtask

   task automatic t_reset_clears();
      strobe();
      wait_cyc(2);
      check("R8 lit before reset", {1'b0, pad_out[0]}, 2'b01);
      hw_rst_n = 1'b0;
      #1;
      check("R1 oe drops at reset", pad_oe, 2'b00);
      do_release(2'b01, 1'b0);
      check("R9 hw reset strap", addr_strap, 2'b01);
      check("R8 coll unlit after reset", {1'b0, pad_out[0]}, 2'b00);
      wait_cyc(4);
      check("R8 coll stays unlit", {1'b0, pad_out[0]}, 2'b00);
   endtask

   initial begin
      t_reset_and_strap();
      t_addr_hold();
      t_link();
      t_coll_single();
      t_coll_retrigger();
      t_reset_clears();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 20000; i++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule